// File: doc/BRIEF.md
# Quarter-Rate Quadrature Mixer

This block turns a stream of real-valued samples, taken at four samples per symbol, into in-phase and quadrature baseband samples without any multiplier. Each accepted sample is first brought into signed two's-complement form. The source may deliver offset (straight) binary or two's-complement words, and for 8-bit converters the lowest bit of the 9-bit word can be forced high. The adapted value is then scaled by one of +1, 0 or -1 on each branch, following a four-step cyclic pattern.

Both branch results go to a later pulse-shaping filter. The adapted, unmixed value travels alongside them for a downstream power detector. Configuration pins are plain levels and are taken together with each accepted sample.

Input and output are valid/ready streams. A sample is accepted on a clock edge where `s_valid` and `s_ready` are both high. A result leaves on an edge where `m_valid` and `m_ready` are both high. While a result waits, the block stops accepting samples, so back-pressure reaches the source in the same cycle.

Top module: `qmix_top`

## Requirements
- R1: A synchronous reset clears `m_valid`, and the first sample accepted after reset uses step 0 of the mixing pattern.
- R2: With `cfg_twos`=0 the input is offset binary, and the adapted value is the input with bit 8 inverted. With `cfg_twos`=1 the input passes unchanged. `m_raw` carries the adapted 9-bit value.
- R3: With `cfg_narrow`=1, bit 0 of the input is forced to 1 before adaptation. The adapted value is then symmetric, and its negation is always exact.
- R4: The I output over steps 0,1,2,3 is +x, 0, -x, 0, where x is the adapted value taken as signed.
- R5: With `cfg_qinv`=0, the Q output over steps 0,1,2,3 is 0, -x, 0, +x.
- R6: With `cfg_qinv`=1, every Q factor changes sign, giving 0, +x, 0, -x.
- R7: The step index is 2 bits wide. It advances by one, wrapping 3 to 0, only on an accepted sample. Idle and stalled cycles leave it unchanged.
- R8: Negating the value -256 (9'h100) gives +255 (9'h0FF). Every other negation is exact.
- R9: A sample accepted on edge k makes `m_valid` high after edge k, with its results on `m_i`, `m_q` and `m_raw` (one register stage).
- R10: `s_ready` equals `!m_valid || m_ready`. While `m_valid` is high and `m_ready` is low, all outputs hold steady.
- R11: The configuration pins are sampled on the edge that accepts the sample they apply to. They may change from one sample to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four times the symbol rate |
| rst | input | 1 | Synchronous reset, active high |
| cfg_twos | input | 1 | 1 = two's-complement input, 0 = offset binary |
| cfg_narrow | input | 1 | 1 = force input bit 0 high (8-bit source) |
| cfg_qinv | input | 1 | 1 = invert the sign of every Q factor |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_data | input | 9 | Input sample, bit 8 MSB |
| m_valid | output | 1 | Output result valid |
| m_ready | input | 1 | Downstream accepts the result |
| m_i | output | 9 | In-phase branch sample, two's complement |
| m_q | output | 9 | Quadrature branch sample, two's complement |
| m_raw | output | 9 | Adapted sample before mixing, two's complement |

## Verification
A step index that is off by one, or that moves on an idle or stalled cycle, makes the zero and nonzero lanes change places. That error shows at the ports on the very next result and stays there for every later sample. Sign faults show up with the first sample that lands on a negating step. Faults in adaptation show on `m_raw` as soon as the sample is accepted. A broken hold under back-pressure shows in the first stalled cycle as a dropped or changed result.

// File: rtl/qmix_pkg.sv
package qmix_pkg;

  localparam int PHASE_W = 2;
  localparam int SEQ_LEN = 1 << PHASE_W;

  typedef enum logic [1:0] {
    MUL_ZERO = 2'd0,
    MUL_POS  = 2'd1,
    MUL_NEG  = 2'd2
  } mul_e;

  // in-phase factor per step: +1, 0, -1, 0
  function automatic mul_e i_factor(input logic [PHASE_W-1:0] step);
    case (step)
      2'd0:    return MUL_POS;
      2'd2:    return MUL_NEG;
      default: return MUL_ZERO;
    endcase
  endfunction

  // quadrature factor per step: 0, -1, 0, +1 (sign swapped when inverted)
  function automatic mul_e q_factor(input logic [PHASE_W-1:0] step, input logic inv);
    case (step)
      2'd1:    return inv ? MUL_POS : MUL_NEG;
      2'd3:    return inv ? MUL_NEG : MUL_POS;
      default: return MUL_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/qmix_fmt.sv
module qmix_fmt #(
  parameter int W = 9
) (
  input  logic [W-1:0] din,
  input  logic         twos,
  input  logic         narrow,
  output logic [W-1:0] dout
);
  logic [W-1:0] lsb_fixed;

  always_comb begin
    lsb_fixed    = din;
    lsb_fixed[0] = din[0] | narrow;
  end

  // offset binary -> two's complement: flip the sign bit
  always_comb begin
    dout      = lsb_fixed;
    dout[W-1] = lsb_fixed[W-1] ^ ~twos;
  end
endmodule

// File: rtl/qmix_phase.sv
module qmix_phase
  import qmix_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  output logic [PHASE_W-1:0] step
);
  always_ff @(posedge clk) begin
    if (rst)      step <= '0;
    else if (adv) step <= step + 1'b1;
  end

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(adv)) |-> (step == PHASE_W'($past(step) + 1'b1))); // R7
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(adv)) |-> $stable(step)); // R7
endmodule

// File: rtl/qmix_lane.sv
module qmix_lane
  import qmix_pkg::*;
#(
  parameter int W    = 9,
  parameter bit IS_Q = 1'b0
) (
  input  logic [PHASE_W-1:0] step,
  input  logic               inv,
  input  logic [W-1:0]       x,
  output logic [W-1:0]       y
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  mul_e factor;

  generate
    if (IS_Q) begin : g_q
      always_comb factor = q_factor(step, inv);
    end else begin : g_i
      always_comb factor = i_factor(step);
    end
  endgenerate

  always_comb begin
    case (factor)
      MUL_POS: y = x;
      MUL_NEG: y = (x == MOST_NEG) ? MOST_POS : (~x + 1'b1);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/qmix_top.sv
module qmix_top
  import qmix_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_twos,
  input  logic         cfg_narrow,
  input  logic         cfg_qinv,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_i,
  output logic [W-1:0] m_q,
  output logic [W-1:0] m_raw
);
  logic               take;
  logic [W-1:0]       adapted;
  logic [PHASE_W-1:0] step;
  logic [W-1:0]       i_mix;
  logic [W-1:0]       q_mix;

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;

  qmix_fmt #(.W(W)) u_fmt (
    .din    (s_data),
    .twos   (cfg_twos),
    .narrow (cfg_narrow),
    .dout   (adapted)
  );

  qmix_phase u_phase (
    .clk  (clk),
    .rst  (rst),
    .adv  (take),
    .step (step)
  );

  qmix_lane #(.W(W), .IS_Q(1'b0)) u_lane_i (
    .step (step),
    .inv  (1'b0),
    .x    (adapted),
    .y    (i_mix)
  );

  qmix_lane #(.W(W), .IS_Q(1'b1)) u_lane_q (
    .step (step),
    .inv  (cfg_qinv),
    .x    (adapted),
    .y    (q_mix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_i     <= '0;
      m_q     <= '0;
      m_raw   <= '0;
    end else if (take) begin
      m_valid <= 1'b1;
      m_i     <= i_mix;
      m_q     <= q_mix;
      m_raw   <= adapted;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_i) && $stable(m_q) && $stable(m_raw))); // R10
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !m_valid |-> s_ready); // R10
  AST_ONE_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (m_i == '0 || m_q == '0)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_raw[0]) |-> (m_i == '0 || m_i == m_raw || m_i == W'(~m_raw + 1'b1))); // R3
  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(take)) |-> m_valid); // R9
endmodule

// File: tb/tb_qmix_top.sv
`timescale 1ns/1ps
module tb_qmix_top;
  localparam int W = 9;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst, cfg_twos, cfg_narrow, cfg_qinv, s_valid, m_ready;
  logic [W-1:0] s_data;
  logic         s_ready, m_valid;
  logic [W-1:0] m_i, m_q, m_raw;

  qmix_top #(.W(W)) dut (
    .clk(clk), .rst(rst), .cfg_twos(cfg_twos), .cfg_narrow(cfg_narrow),
    .cfg_qinv(cfg_qinv), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q), .m_raw(m_raw)
  );

  typedef struct {
    int    i;
    int    q;
    int    raw;
    string ti;
    string tq;
    string tr;
  } exp_t;

  exp_t  expq[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  int    ph = 0;
  string stag = "";

  function automatic int to_s(input int x);
    int m;
    m = x & 511;
    return (m >= 256) ? m - 512 : m;
  endfunction

  function automatic int sneg(input int v);
    return (v == -256) ? 255 : -v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit r, input bit v, input int d, input bit tw,
                     input bit nr, input bit qi, input bit rdy);
    bit   acc_in, acc_out;
    int   x, val;
    exp_t e;
    rst = r; s_valid = v; s_data = d[W-1:0];
    cfg_twos = tw; cfg_narrow = nr; cfg_qinv = qi; m_ready = rdy;
    #1;
    acc_in  = !r && v && s_ready;
    acc_out = !r && m_valid && m_ready;
    if (r) begin
      expq.delete();
      ph = 0;
    end else begin
      if (acc_out) void'(expq.pop_front());
      if (acc_in) begin
        x = d & 511;
        if (nr) x = x | 1;
        if (!tw) x = x ^ 256;
        val   = to_s(x);
        e.raw = val;
        e.i   = (ph == 0) ? val : (ph == 2) ? sneg(val) : 0;
        if (ph == 1)      e.q = qi ? val : sneg(val);
        else if (ph == 3) e.q = qi ? sneg(val) : val;
        else              e.q = 0;
        e.ti = (stag != "") ? stag : "R4";
        e.tq = (stag != "") ? stag : (qi ? "R6" : "R5");
        e.tr = (stag != "") ? stag : "R2";
        expq.push_back(e);
        ph = (ph + 1) % 4;
      end
    end
    @(posedge clk);
    #1;
    chk((stag != "") ? stag : "R9", int'(m_valid), (expq.size() > 0) ? 1 : 0);
    chk((stag != "") ? stag : "R10", int'(s_ready), int'(!m_valid || m_ready));
    if (m_valid && expq.size() > 0) begin
      chk(expq[0].ti, to_s(int'(m_i)), expq[0].i);
      chk(expq[0].tq, to_s(int'(m_q)), expq[0].q);
      chk(expq[0].tr, to_s(int'(m_raw)), expq[0].raw);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL R9 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state and first step after reset
    stag = "R1";
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, 1, 0, 0, 1);
    cyc(0, 0, 0, 1, 0, 0, 1);
    chk("R1", int'(s_ready), 1);
    cyc(0, 1, 100, 1, 0, 0, 1);
    cyc(0, 0, 0, 1, 0, 0, 1);

    // R4/R5: two's-complement stream, free-flowing
    stag = "";
    for (int k = 0; k < 40; k++) cyc(0, 1, $urandom_range(0, 511), 1, 0, 0, 1);
    // R2: offset binary stream
    for (int k = 0; k < 40; k++) cyc(0, 1, $urandom_range(0, 511), 0, 0, 0, 1);
    // R6: Q inversion
    for (int k = 0; k < 40; k++) cyc(0, 1, $urandom_range(0, 511), 1, 0, 1, 1);

    // R3: forced LSB, both formats, extremes included
    stag = "R3";
    for (int k = 0; k < 8; k++) cyc(0, 1, 256, 1, 1, k[1], 1);
    for (int k = 0; k < 8; k++) cyc(0, 1, 0, 0, 1, k[2], 1);
    for (int k = 0; k < 40; k++) cyc(0, 1, $urandom_range(0, 511), k[0], 1, k[1], 1);

    // R8: most negative value on every step, both Q signs
    stag = "R8";
    for (int k = 0; k < 8; k++) cyc(0, 1, 256, 1, 0, k[2], 1);
    for (int k = 0; k < 4; k++) cyc(0, 1, 0, 0, 0, 0, 1);

    // R7: gaps in the input stream must not move the step
    stag = "R7";
    for (int k = 0; k < 60; k++)
      cyc(0, ($urandom_range(0, 2) == 0), $urandom_range(0, 511), 1, 0, 0, 1);

    // R10: random back-pressure
    stag = "R10";
    for (int k = 0; k < 150; k++)
      cyc(0, $urandom_range(0, 1), $urandom_range(0, 511), 1, 0, 0, $urandom_range(0, 1));

    // R11: configuration changes per sample under back-pressure
    stag = "R11";
    for (int k = 0; k < 150; k++)
      cyc(0, $urandom_range(0, 1), $urandom_range(0, 511), $urandom_range(0, 1),
          $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));

    // R1: reset in mid-stream restarts at step 0, drops pending result
    stag = "R1";
    cyc(0, 1, 77, 1, 0, 0, 0);
    cyc(1, 1, 55, 1, 0, 0, 0);
    cyc(1, 0, 0, 1, 0, 0, 1);
    for (int k = 0; k < 4; k++) cyc(0, 1, 200 + k, 1, 0, 0, 1);
    cyc(0, 0, 0, 1, 0, 0, 1);

    summary();
    $finish;
  end
endmodule